// File: doc/BRIEF.md
# Language Card Bank Switch Controller

This block holds the switching state of a 16 KB language card, a RAM expansion that sits at the top of a small processor's address map. It watches processor accesses to a window of sixteen control addresses. On each access it updates four state bits: RAM read enable, RAM write enable, a pre-write latch and the select between two 4 KB banks. A downstream page mapper uses these bits to send reads and writes either to card RAM or to ROM. The controller also drives a one-cycle change pulse so the mapper knows when to recompute its tables. It presents the bank and read-enable flags as status bytes for software to read back.

The address decoder that recognises the window is outside this block. It presents the low nibble of the address, a one-cycle access strobe and the direction. RAM and ROM storage and the page mapping itself are also handled elsewhere.

Top module: `lcard_bank_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the state is write-enable 1, bank select 1 (second bank), read-enable 0, pre-write 0, and the change pulse is 0.
- R2: On an access whose address bit 0 is 1, pre-write becomes 1 if the access is a read (acc_wr=0) and 0 if it is a write (acc_wr=1).
- R3: An odd-address read that finds pre-write already 1 sets write-enable to 1, so two odd reads with no access in between enable writes.
- R4: An access whose address bit 0 is 0, read or write, clears both write-enable and pre-write.
- R5: Read-enable after an odd-address access equals address bit 1; after an even-address access it equals the inverse of address bit 1.
- R6: Bank select after any access equals the inverse of address bit 3, so nibbles 0x0 to 0x7 select the second bank (bank2=1).
- R7: In a cycle with acc_stb low, no state bit changes, whatever the address and direction inputs are.
- R8: chg_pulse is 1 for exactly the one cycle after a clock edge at which any state bit changed, and 0 otherwise.
- R9: The status byte carries bank2 (sts_sel=0) or read-enable (sts_sel=1) in bit 7, with every other bit 0.
- R10: An odd-address write, or an odd-address read with pre-write clear, leaves write-enable at its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_stb | input | 1 | One-cycle strobe marking an access to the control window |
| acc_wr | input | 1 | Access direction, 1 = write, 0 = read |
| acc_addr | input | 4 | Low nibble of the accessed address |
| sts_sel | input | 1 | Status select, 0 = bank flag, 1 = read-enable flag |
| ram_rd_en | output | 1 | Reads of the upper area go to card RAM |
| ram_wr_en | output | 1 | Writes of the upper area go to card RAM |
| prewrite | output | 1 | Pre-write latch |
| bank2 | output | 1 | Second 4 KB bank selected |
| chg_pulse | output | 1 | One-cycle pulse after any state bit changed |
| sts_data | output | DATA_W | Status byte, flag in bit FLAG_BIT |

## Verification
The hardest state to reach is a write-enable that rises from 0 to 1. Reset leaves writes already enabled, so the stimulus first has to clear them with an even access. It then has to arrange two odd reads with no write or even access between them. The directed stimulus does this, and it also breaks the pair with an odd write to show that the break leaves writes disabled. A long stretch of random accesses with idle gaps, compared every cycle against a behavioural model, then covers the remaining orderings.

// File: rtl/lc_pkg.sv
package lc_pkg;

   // bit positions within the address nibble that steer the state
   localparam int unsigned LC_NIB_W    = 4;
   localparam int unsigned LC_ODD_BIT  = 0;
   localparam int unsigned LC_RSEL_BIT = 1;
   localparam int unsigned LC_BANK_BIT = 3;

   typedef struct packed {
      logic rd_en;
      logic wr_en;
      logic pre;
      logic bank2;
   } lc_state_t;

   localparam lc_state_t LC_RESET = '{rd_en: 1'b0, wr_en: 1'b1, pre: 1'b0, bank2: 1'b1};

endpackage

// File: rtl/lc_access_decode.sv
module lc_access_decode
   import lc_pkg::*;
(
   input  logic                nib_odd,
   input  logic                nib_rsel,
   input  logic                nib_bank,
   input  logic                is_write,
   input  logic                cur_pre,
   input  logic                cur_wr_en,
   output lc_state_t           nxt
);

   always_comb begin
      nxt.bank2 = ~nib_bank;
      if (nib_odd) begin
         nxt.wr_en = (~is_write & cur_pre) ? 1'b1 : cur_wr_en;
         nxt.pre   = ~is_write;
         nxt.rd_en = nib_rsel;
      end else begin
         nxt.wr_en = 1'b0;
         nxt.pre   = 1'b0;
         nxt.rd_en = ~nib_rsel;
      end
   end

endmodule

// File: rtl/lc_state_bank.sv
module lc_state_bank
   import lc_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      upd,
   input  lc_state_t nxt,
   output lc_state_t cur,
   output logic      chg
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur <= LC_RESET;
         chg <= 1'b0;
      end else begin
         chg <= upd && (nxt != cur);
         if (upd) cur <= nxt;
      end
   end

endmodule

// File: rtl/lc_status_port.sv
module lc_status_port #(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned FLAG_BIT = 7
) (
   input  logic              sel_rd,
   input  logic              flag_bank,
   input  logic              flag_rd,
   output logic [DATA_W-1:0] data
);

   logic flag;
   assign flag = sel_rd ? flag_rd : flag_bank;

   for (genvar gi = 0; gi < DATA_W; gi++) begin : g_bit
      if (gi == FLAG_BIT) begin : g_flag
         assign data[gi] = flag;
      end else begin : g_zero
         assign data[gi] = 1'b0;
      end
   end

endmodule

// File: rtl/lcard_bank_ctrl.sv
module lcard_bank_ctrl
   import lc_pkg::*;
#(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned FLAG_BIT = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_stb,
   input  logic              acc_wr,
   input  logic [3:0]        acc_addr,
   input  logic              sts_sel,
   output logic              ram_rd_en,
   output logic              ram_wr_en,
   output logic              prewrite,
   output logic              bank2,
   output logic              chg_pulse,
   output logic [DATA_W-1:0] sts_data
);

   localparam int unsigned TOP_BIT = DATA_W - 1;

   if (FLAG_BIT > TOP_BIT) begin : g_bad_flag
      $error("FLAG_BIT must lie inside the status word");
   end
   if (LC_NIB_W != 4) begin : g_bad_nib
      $error("address nibble must be four bits wide");
   end

   lc_state_t st_cur, st_nxt;

   lc_access_decode u_dec (
      .nib_odd   (acc_addr[LC_ODD_BIT]),
      .nib_rsel  (acc_addr[LC_RSEL_BIT]),
      .nib_bank  (acc_addr[LC_BANK_BIT]),
      .is_write  (acc_wr),
      .cur_pre   (st_cur.pre),
      .cur_wr_en (st_cur.wr_en),
      .nxt       (st_nxt)
   );

   lc_state_bank u_st (
      .clk   (clk),
      .rst_n (rst_n),
      .upd   (acc_stb),
      .nxt   (st_nxt),
      .cur   (st_cur),
      .chg   (chg_pulse)
   );

   lc_status_port #(.DATA_W(DATA_W), .FLAG_BIT(FLAG_BIT)) u_sts (
      .sel_rd    (sts_sel),
      .flag_bank (st_cur.bank2),
      .flag_rd   (st_cur.rd_en),
      .data      (sts_data)
   );

   assign ram_rd_en = st_cur.rd_en;
   assign ram_wr_en = st_cur.wr_en;
   assign prewrite  = st_cur.pre;
   assign bank2     = st_cur.bank2;

endmodule

// File: rtl/lcard_bank_ctrl_chk.sv
module lcard_bank_ctrl_chk #(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned FLAG_BIT = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              acc_stb,
   input logic              acc_wr,
   input logic [3:0]        acc_addr,
   input logic              sts_sel,
   input logic              ram_rd_en,
   input logic              ram_wr_en,
   input logic              prewrite,
   input logic              bank2,
   input logic              chg_pulse,
   input logic [DATA_W-1:0] sts_data
);

   logic [3:0] st;
   assign st = {ram_rd_en, ram_wr_en, prewrite, bank2};

   p_reset_r1: assert property (@(posedge clk)
      !rst_n |=> (ram_wr_en && bank2 && !ram_rd_en && !prewrite && !chg_pulse));

   p_odd_pre_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_stb && acc_addr[0]) |=> (prewrite == !$past(acc_wr)));

   p_wr_needs_pre_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ram_wr_en) |-> ($past(prewrite) && !$past(acc_wr) && $past(acc_addr[0])));

   p_even_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_stb && !acc_addr[0]) |=> (!ram_wr_en && !prewrite));

   p_rd_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
      acc_stb |=> (ram_rd_en == ($past(acc_addr[1]) ~^ $past(acc_addr[0]))));

   p_bank_r6: assert property (@(posedge clk) disable iff (!rst_n)
      acc_stb |=> (bank2 == !$past(acc_addr[3])));

   p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_stb |=> $stable(st));

   p_chg_r8: assert property (@(posedge clk) disable iff (!rst_n)
      chg_pulse == (st != $past(st)));

   p_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(sts_data) <= 1) &&
      (sts_data[FLAG_BIT] == (sts_sel ? ram_rd_en : bank2)));

endmodule

bind lcard_bank_ctrl lcard_bank_ctrl_chk #(.DATA_W(DATA_W), .FLAG_BIT(FLAG_BIT)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .acc_stb   (acc_stb),
   .acc_wr    (acc_wr),
   .acc_addr  (acc_addr),
   .sts_sel   (sts_sel),
   .ram_rd_en (ram_rd_en),
   .ram_wr_en (ram_wr_en),
   .prewrite  (prewrite),
   .bank2     (bank2),
   .chg_pulse (chg_pulse),
   .sts_data  (sts_data)
);

// File: tb/test_lcard_bank_ctrl.sv
module test_lcard_bank_ctrl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       acc_stb = 1'b0;
   logic       acc_wr = 1'b0;
   logic [3:0] acc_addr = 4'h0;
   logic       sts_sel = 1'b0;
   logic       ram_rd_en, ram_wr_en, prewrite, bank2, chg_pulse;
   logic [7:0] sts_data;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   bit run_cmp = 1'b0;

   // behavioural reference
   int m_rd = 0, m_wr = 1, m_pre = 0, m_bank = 1, m_chg = 0;

   always #10 clk = ~clk;

   lcard_bank_ctrl i_lcard_bank_ctrl (
      .clk(clk), .rst_n(rst_n), .acc_stb(acc_stb), .acc_wr(acc_wr),
      .acc_addr(acc_addr), .sts_sel(sts_sel), .ram_rd_en(ram_rd_en),
      .ram_wr_en(ram_wr_en), .prewrite(prewrite), .bank2(bank2),
      .chg_pulse(chg_pulse), .sts_data(sts_data)
   );

   always @(posedge clk) begin
      int n_rd, n_wr, n_pre, n_bank;
      if (!rst_n) begin
         m_rd = 0; m_wr = 1; m_pre = 0; m_bank = 1; m_chg = 0;
      end else begin
         m_chg = 0;
         if (acc_stb) begin
            n_bank = acc_addr[3] ? 0 : 1;
            if (acc_addr[0]) begin
               n_wr  = (!acc_wr && m_pre == 1) ? 1 : m_wr;
               n_pre = acc_wr ? 0 : 1;
               n_rd  = acc_addr[1] ? 1 : 0;
            end else begin
               n_wr = 0; n_pre = 0;
               n_rd = acc_addr[1] ? 0 : 1;
            end
            m_chg = (n_rd != m_rd || n_wr != m_wr || n_pre != m_pre || n_bank != m_bank) ? 1 : 0;
            m_rd = n_rd; m_wr = n_wr; m_pre = n_pre; m_bank = n_bank;
         end
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (run_cmp) begin
         chk("R5 ram_rd_en", ram_rd_en, m_rd);
         chk("R3 ram_wr_en", ram_wr_en, m_wr);
         chk("R2 prewrite", prewrite, m_pre);
         chk("R6 bank2", bank2, m_bank);
         chk("R8 chg_pulse", chg_pulse, m_chg);
         chk("R9 sts_data", sts_data, (sts_sel ? m_rd : m_bank) << 7);
      end
   end

   task automatic acc(input logic [3:0] a, input logic w);
      @(negedge clk); #2;
      acc_stb = 1'b1; acc_addr = a; acc_wr = w;
      @(negedge clk); #2;
      acc_stb = 1'b0; acc_addr = $urandom; acc_wr = $urandom;
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R7 watchdog actual=running expected=finished");
         summary();
      end
   end

   initial begin
      logic [3:0] sv_state;
      repeat (3) @(negedge clk);
      // R1: state held in reset
      chk("R1 wr_en", ram_wr_en, 1); chk("R1 bank2", bank2, 1);
      chk("R1 rd_en", ram_rd_en, 0); chk("R1 pre", prewrite, 0);
      chk("R1 chg", chg_pulse, 0);
      #2 rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after", {ram_rd_en, ram_wr_en, prewrite, bank2}, 4'b0101);
      run_cmp = 1'b1;

      // R4: even read clears write enable
      acc(4'h0, 1'b0);
      chk("R4 wr_en", ram_wr_en, 0); chk("R4 pre", prewrite, 0);
      chk("R5 even a1=0", ram_rd_en, 1); chk("R6 bank 0x0", bank2, 1);
      // R2 then broken pair: odd read, odd write, odd read -> still disabled
      acc(4'h1, 1'b0); chk("R2 pre set", prewrite, 1); chk("R10 wr hold", ram_wr_en, 0);
      acc(4'h1, 1'b1); chk("R2 pre clr", prewrite, 0); chk("R10 odd write", ram_wr_en, 0);
      acc(4'h9, 1'b0); chk("R10 single read", ram_wr_en, 0); chk("R6 bank 0x9", bank2, 0);
      // R3: second consecutive odd read enables
      acc(4'hB, 1'b0); chk("R3 enable", ram_wr_en, 1); chk("R5 odd a1=1", ram_rd_en, 1);
      // R10: odd write with writes on keeps them on
      acc(4'h3, 1'b1); chk("R10 keep", ram_wr_en, 1); chk("R2 pre write", prewrite, 0);
      // R4: even write clears
      acc(4'hA, 1'b1); chk("R4 even write", ram_wr_en, 0); chk("R5 even a1=1", ram_rd_en, 0);
      // R7: idle cycles with wandering inputs
      sv_state = {ram_rd_en, ram_wr_en, prewrite, bank2};
      for (int i = 0; i < 8; i++) begin
         @(negedge clk); #2; acc_addr = 4'(i); acc_wr = i[0];
      end
      @(negedge clk);
      chk("R7 idle", {ram_rd_en, ram_wr_en, prewrite, bank2}, sv_state);
      chk("R8 idle", chg_pulse, 0);
      // R9: status select both ways
      #2 sts_sel = 1'b1; #2; chk("R9 rd flag", sts_data, {ram_rd_en, 7'd0});
      sts_sel = 1'b0; #2; chk("R9 bank flag", sts_data, {bank2, 7'd0});
      // R8: repeated identical access yields no pulse
      acc(4'h8, 1'b0); acc(4'h8, 1'b0); chk("R8 no change", chg_pulse, 0);
      // all sixteen addresses both directions
      for (int a = 0; a < 16; a++) begin
         acc(4'(a), 1'b0); acc(4'(a), 1'b1);
      end
      // random traffic with gaps
      for (int k = 0; k < 3000; k++) begin
         @(negedge clk); #2;
         acc_stb = ($urandom % 3) != 0;
         acc_addr = $urandom; acc_wr = ($urandom % 4) == 0;
         sts_sel = $urandom;
      end
      @(negedge clk); #2 acc_stb = 1'b0;
      repeat (3) @(negedge clk);
      done = 1'b1;
      summary();
   end

endmodule